// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block forms data-space addresses for indirect loads and stores. It holds a 32-entry file of 8-bit general registers. The top six entries are paired into three 16-bit pointers. For each access, the caller picks a pointer and an addressing mode. The unit returns the effective address in the same cycle. When the mode changes the pointer, the unit writes the new value back into the register pair at the next clock edge.

Other instructions reach the register file through a byte-wide write port and a combinational read port. A pointer therefore always reflects the latest byte writes to its pair. Auto-update traffic and ordinary register writes share the same storage, so they can land on the same entry in the same cycle.

Top module: `ptr_addr_unit`

## Requirements
- R1: On reset (rst_n low), all 32 registers read back as zero.
- R2: Pointer select 0 uses register 26 as its low byte and register 27 as its high byte. Select 1 uses 28 (low) and 29 (high). Select 2 uses 30 (low) and 31 (high).
- R3: In mode 0 (plain), eff_addr equals the selected pointer, and the pointer keeps its value.
- R4: In mode 1 (offset), eff_addr is the pointer plus the 6-bit displacement taken as unsigned, modulo 65536. The pointer keeps its value. This mode is legal only for selects 1 and 2.
- R5: In mode 2 (post-increment), eff_addr is the old pointer value. At the next edge, both bytes of the pointer become old+1 modulo 65536.
- R6: In mode 3 (pre-decrement), eff_addr is the old value minus 1 modulo 65536. At the next edge, both bytes of the pointer become that same value.
- R7: Select 3, or select 0 combined with mode 1, is illegal. An illegal request gives eff_addr 0. While acc_en is high, it also raises acc_err, and no pointer register changes.
- R8: While wr_en is high, wr_data is stored in register wr_idx at the clock edge. rd_data always shows register rd_idx.
- R9: If a pointer update and a port write hit the same register in the same cycle, the register takes the pointer update. A port write to any other register in that cycle still takes effect.
- R10: A pointer changes only when acc_en is high in a legal mode 2 or mode 3 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request valid |
| acc_sel | input | 2 | Pointer select: 0, 1 or 2 |
| acc_mode | input | 2 | 0 plain, 1 offset, 2 post-increment, 3 pre-decrement |
| acc_disp | input | 6 | Unsigned displacement |
| eff_addr | output | 16 | Effective data-space address |
| acc_err | output | 1 | Illegal select/mode combination requested |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 8 | Register read data |

## Verification
Pointer auto-update and the general write port can both target the same register in one cycle. The bench provokes this by issuing post-increment and pre-decrement accesses while writing to the low byte or the high byte of the pair being updated. It judges the result by reading the pair back and expecting the updated pointer value in both bytes. The same cycle also carries writes to an unrelated register, and to a pair in offset or illegal mode, and those writes are expected to land. A sweep covers every select and mode over pointer values at the wrap boundaries.

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
  parameter int DW    = 8,
  parameter int NREG  = 32,
  parameter int DISPW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic [1:0]               acc_sel,
  input  logic [1:0]               acc_mode,
  input  logic [DISPW-1:0]         acc_disp,
  output logic [2*DW-1:0]          eff_addr,
  output logic                     acc_err,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(NREG)-1:0]  rd_idx,
  output logic [DW-1:0]            rd_data
);
  localparam int AW   = 2 * DW;
  localparam int IW   = $clog2(NREG);
  localparam int BASE = NREG - 6;

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] lo_idx, hi_idx;
  logic [AW-1:0] ptr_cur, ptr_next;
  logic          illegal, upd;

  function automatic logic [AW-1:0] ptr_of(input logic [1:0] s);
    logic [IW-1:0] l;
    l = IW'(BASE + 2 * int'(s));
    return {regs[l | IW'(1)], regs[l]};
  endfunction

  assign lo_idx  = IW'(BASE + 2 * int'(acc_sel));
  assign hi_idx  = lo_idx | IW'(1);
  assign ptr_cur = {regs[hi_idx], regs[lo_idx]};
  assign illegal = (acc_sel == 2'd3) || (acc_sel == 2'd0 && acc_mode == 2'd1);
  assign acc_err = acc_en && illegal;
  assign upd     = acc_en && !illegal && acc_mode[1];
  assign rd_data = regs[rd_idx];

  always_comb begin
    ptr_next = ptr_cur;
    eff_addr = ptr_cur;
    if (illegal) begin
      eff_addr = '0;
    end else begin
      case (acc_mode)
        2'd1: eff_addr = ptr_cur + AW'(acc_disp);
        2'd2: ptr_next = ptr_cur + AW'(1);
        2'd3: begin
          ptr_next = ptr_cur - AW'(1);
          eff_addr = ptr_next;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wr_en) regs[wr_idx] <= wr_data;
      if (upd) begin
        regs[lo_idx] <= ptr_next[DW-1:0];
        regs[hi_idx] <= ptr_next[AW-1:DW];
      end
    end
  end

  a_r5_postinc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_err && acc_mode == 2'd2)
      |=> ptr_of($past(acc_sel)) == $past(eff_addr) + AW'(1));

  a_r6_predec: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_err && acc_mode == 2'd3)
      |=> ptr_of($past(acc_sel)) == $past(eff_addr));

  a_r4_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_err && acc_mode == 2'd1 && !wr_en)
      |=> ptr_of($past(acc_sel)) == $past(ptr_of(acc_sel)));

  a_r7_err_noupdate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !wr_en)
      |=> $stable({regs[BASE+5], regs[BASE+4], regs[BASE+3],
                   regs[BASE+2], regs[BASE+1], regs[BASE]}));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !wr_en)
      |=> $stable({regs[BASE+5], regs[BASE+4], regs[BASE+3],
                   regs[BASE+2], regs[BASE+1], regs[BASE]}));

  a_r7_err_addr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> eff_addr == '0);
endmodule

// File: tb/ptr_addr_unit_tb.sv
module ptr_addr_unit_tb;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_err, wr_en = 0;
  logic [1:0] acc_sel = 0, acc_mode = 0;
  logic [5:0] acc_disp = 0;
  logic [15:0] eff_addr;
  logic [4:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [7:0] m [32];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ptr_addr_unit u_dut (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel),
    .acc_mode(acc_mode), .acc_disp(acc_disp), .eff_addr(eff_addr), .acc_err(acc_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input int idx);
    rd_idx = 5'(idx);
    #1;
    check(req, {8'h00, rd_data}, {8'h00, m[idx]});
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    m[idx] = d;
  endtask

  task automatic access(input logic [1:0] s, input logic [1:0] md, input logic [5:0] dsp,
                        input logic we, input int widx, input logic [7:0] wd, input string req);
    logic [15:0] p, exp_a, nxt;
    logic bad;
    int lo;
    lo = 26 + 2 * int'(s);
    bad = (s == 2'd3) || (s == 2'd0 && md == 2'd1);
    p = bad ? 16'h0 : {m[lo+1], m[lo]};
    nxt = p;
    exp_a = p;
    if (bad) exp_a = 16'h0;
    else if (md == 2'd1) exp_a = p + 16'(dsp);
    else if (md == 2'd2) nxt = p + 16'd1;
    else if (md == 2'd3) begin nxt = p - 16'd1; exp_a = nxt; end
    @(negedge clk);
    acc_en = 1; acc_sel = s; acc_mode = md; acc_disp = dsp;
    wr_en = we; wr_idx = 5'(widx); wr_data = wd;
    #1;
    check({req, " addr"}, eff_addr, exp_a);
    check("R7 err", {15'h0, acc_err}, {15'h0, bad});
    @(posedge clk); #1;
    acc_en = 0; wr_en = 0;
    if (we) m[widx] = wd;
    if (!bad && md[1]) begin m[lo] = nxt[7:0]; m[lo+1] = nxt[15:8]; end
    for (int i = 26; i < 32; i++) read_chk({req, " R10 ptr regs"}, i);
    if (we) read_chk("R9 port write", widx);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] pv [8] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100,
                            16'h7FFF, 16'hFFFF, 16'hFFC1, 16'h1234};
    logic [5:0] dv [3] = '{6'd0, 6'd1, 6'd63};
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 32; i++) read_chk("R1 reset", i);
    // R8: every register written and read back
    for (int i = 0; i < 32; i++) wr_reg(i, 8'(i * 7 + 3));
    for (int i = 0; i < 32; i++) read_chk("R8 write/read", i);
    // R2..R7 sweep over pointer values, selects and modes
    for (int v = 0; v < 8; v++)
      for (int s = 0; s < 4; s++) begin
        if (s < 3) begin
          wr_reg(26 + 2 * s, pv[v][7:0]);
          wr_reg(27 + 2 * s, pv[v][15:8]);
        end
        for (int md = 0; md < 4; md++)
          if (md == 1)
            for (int d = 0; d < 3; d++) access(2'(s), 2'(md), dv[d], 0, 0, 0, "R4");
          else
            access(2'(s), 2'(md), 6'd5, 0, 0, 0,
                   md == 0 ? "R3" : (md == 2 ? "R5" : "R6"));
      end
    // R2 mapping: distinct pointers, plain reads
    wr_reg(26, 8'h11); wr_reg(27, 8'h22); wr_reg(28, 8'h33);
    wr_reg(29, 8'h44); wr_reg(30, 8'h55); wr_reg(31, 8'h66);
    access(2'd0, 2'd0, 0, 0, 0, 0, "R2 X");
    access(2'd1, 2'd0, 0, 0, 0, 0, "R2 Y");
    access(2'd2, 2'd0, 0, 0, 0, 0, "R2 Z");
    // R9 collisions
    wr_reg(28, 8'hFF); wr_reg(29, 8'h00);
    access(2'd1, 2'd2, 0, 1, 28, 8'hA5, "R9 postinc vs lo");
    access(2'd1, 2'd2, 0, 1, 29, 8'h5A, "R9 postinc vs hi");
    access(2'd2, 2'd3, 0, 1, 31, 8'hC3, "R9 predec vs hi");
    access(2'd2, 2'd3, 0, 1, 30, 8'h3C, "R9 predec vs lo");
    access(2'd1, 2'd3, 0, 1, 26, 8'h77, "R9 other reg");
    access(2'd1, 2'd1, 6'd9, 1, 28, 8'h99, "R9 offset write lands");
    access(2'd0, 2'd1, 6'd9, 1, 26, 8'h88, "R7 illegal write lands");
    access(2'd3, 2'd2, 0, 0, 0, 0, "R7 select3");
    access(2'd0, 2'd3, 0, 1, 5, 8'h42, "R9 unrelated");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule